// File: doc/BRIEF.md
# Compare Output Pin Controller

The block holds the output-compare state bit of each compare channel of a timer and decides what reaches the channel's port pin. When a compare match arrives, a 2-bit output mode tells the block to set, clear or toggle the state bit, or to leave it alone. Software can also pulse a force strobe in a non-PWM configuration. The strobe updates the state bit exactly as a match would, but it reaches no interrupt flag and no counter, because the block has no connection to either.

When a channel's mode is nonzero, its pin carries the state bit and the general-purpose port data is ignored. When the mode is zero, the pin returns to the port data. The pin's output enable always follows the port direction bit. This means software can preset the state bit with force strobes before it drives the pin. Mode changes are not buffered and affect the pin in the same cycle. The number of channels is a parameter, and each channel is independent of the others.

Top module: `oc_pin_ctrl`

## Requirements
- R1: After the asynchronous reset, every internal compare state bit is 0.
- R2: On a compare event, mode 2'b01 toggles the state bit, mode 2'b10 clears it and mode 2'b11 sets it. The bit changes at the next rising clock edge.
- R3: With mode 2'b00, a compare event leaves the state bit unchanged, and the pin carries the port data bit.
- R4: With any nonzero mode, the pin carries the internal state bit instead of the port data bit.
- R5: The pin output enable always equals the port direction bit, whatever the mode.
- R6: A force strobe while the PWM indicator is low acts as a compare event with the same mode action as a match.
- R7: A force strobe while the PWM indicator is high is ignored and leaves the state bit unchanged.
- R8: A match and a valid force strobe in the same cycle make one compare event, so a toggle is applied only once.
- R9: Without a compare event, the state bit holds its value across changes of the PWM indicator and of the mode.
- R10: A change of the mode bits changes the pin source in the same cycle, with no register delay.
- R11: Each channel updates only from its own match, force and mode inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| match_i | input | NUM_CH | Per-channel compare match pulse |
| mode_i | input | 2*NUM_CH | Per-channel output mode; channel k uses bits [2k+1:2k] |
| pwm_i | input | 1 | High while the timer is in a PWM configuration |
| force_i | input | NUM_CH | Per-channel single-cycle force strobe |
| port_data_i | input | NUM_CH | General-purpose port data bit per pin |
| port_dir_i | input | NUM_CH | Port direction bit per pin, 1 = output |
| pin_o | output | NUM_CH | Pin value |
| pin_oe_o | output | NUM_CH | Pin output enable |

## Verification
The state bit is hidden whenever the mode is zero or the direction bit selects input. This makes it hardest to see the bit after a mode-00 event or after an ignored strobe in PWM. After every stimulus cycle, the bench drives a probe cycle that sets mode 2'b11 with the direction set and no event. In that cycle the pin shows the stored bit directly, and the set mode cannot act because no event is present. The sweep covers every combination of mode, match, force, PWM, port data and direction for both channels, with each channel on a different pattern. Targeted sequences then hold the state across PWM and mode changes and switch the mode mid-cycle.

// File: rtl/oc_cmp_pkg.sv
package oc_cmp_pkg;
  typedef enum logic [1:0] {
    OC_OFF    = 2'b00,
    OC_TOGGLE = 2'b01,
    OC_CLEAR  = 2'b10,
    OC_SET    = 2'b11
  } oc_mode_e;
endpackage

// File: rtl/oc_state_reg.sv
module oc_state_reg
  import oc_cmp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       match_i,
  input  logic       force_i,
  input  logic       pwm_i,
  input  logic [1:0] mode_i,
  output logic       state_o
);
  logic     evt;
  logic     state_d;
  oc_mode_e mode;

  assign mode = oc_mode_e'(mode_i);
  assign evt  = match_i | (force_i & ~pwm_i);  // forced event only outside PWM

  always_comb begin
    state_d = state_o;
    if (evt) begin
      unique case (mode)
        OC_TOGGLE: state_d = ~state_o;
        OC_CLEAR:  state_d = 1'b0;
        OC_SET:    state_d = 1'b1;
        default:   state_d = state_o;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_o <= 1'b0;
    else         state_o <= state_d;
  end

  assert_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i && mode_i == 2'b11) |=> state_o);
  assert_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i && mode_i == 2'b10) |=> !state_o);
  assert_toggle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i && mode_i == 2'b01) |=> state_o != $past(state_o));
  assert_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00) |=> $stable(state_o));
  assert_pwm_force_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!match_i && pwm_i) |=> $stable(state_o));
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!match_i && !force_i) |=> $stable(state_o));
endmodule

// File: rtl/oc_pin_mux.sv
module oc_pin_mux (
  input  logic [1:0] mode_i,
  input  logic       state_i,
  input  logic       port_data_i,
  input  logic       port_dir_i,
  output logic       pin_o,
  output logic       pin_oe_o
);
  logic own;
  assign own      = |mode_i;
  assign pin_o    = own ? state_i : port_data_i;
  assign pin_oe_o = port_dir_i;  // direction never taken over
endmodule

// File: rtl/oc_pin_ctrl.sv
module oc_pin_ctrl #(
  parameter int NUM_CH = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_CH-1:0]   match_i,
  input  logic [2*NUM_CH-1:0] mode_i,
  input  logic                pwm_i,
  input  logic [NUM_CH-1:0]   force_i,
  input  logic [NUM_CH-1:0]   port_data_i,
  input  logic [NUM_CH-1:0]   port_dir_i,
  output logic [NUM_CH-1:0]   pin_o,
  output logic [NUM_CH-1:0]   pin_oe_o
);
  localparam int MW = 2;

  logic [NUM_CH-1:0] state;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    logic [MW-1:0] ch_mode;
    assign ch_mode = mode_i[MW*k +: MW];

    oc_state_reg u_state (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .match_i (match_i[k]),
      .force_i (force_i[k]),
      .pwm_i   (pwm_i),
      .mode_i  (ch_mode),
      .state_o (state[k])
    );

    oc_pin_mux u_mux (
      .mode_i      (ch_mode),
      .state_i     (state[k]),
      .port_data_i (port_data_i[k]),
      .port_dir_i  (port_dir_i[k]),
      .pin_o       (pin_o[k]),
      .pin_oe_o    (pin_oe_o[k])
    );

    assert_pin_src_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ch_mode != 2'b00) |-> (pin_o[k] == state[k]));
    assert_pin_port_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ch_mode == 2'b00) |-> (pin_o[k] == port_data_i[k]));
    assert_force_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (force_i[k] && !pwm_i && ch_mode == 2'b11) |=> state[k]);
  end

  assert_oe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_oe_o == port_dir_i);
endmodule

// File: tb/sim_oc_pin_ctrl.sv
module sim_oc_pin_ctrl;
  localparam int  NUM_CH = 2;
  localparam time PERIOD = 10;

  logic                clk = 1'b0;
  logic                rst_ni = 1'b0;
  logic [NUM_CH-1:0]   match_i = '0;
  logic [2*NUM_CH-1:0] mode_i = '0;
  logic                pwm_i = 1'b0;
  logic [NUM_CH-1:0]   force_i = '0;
  logic [NUM_CH-1:0]   port_data_i = '0;
  logic [NUM_CH-1:0]   port_dir_i = '0;
  logic [NUM_CH-1:0]   pin_o, pin_oe_o;

  int checks = 0;
  int errors = 0;
  logic [NUM_CH-1:0] exp_st = '0;

  always #(PERIOD/2) clk = ~clk;

  oc_pin_ctrl #(.NUM_CH(NUM_CH)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .match_i(match_i), .mode_i(mode_i),
    .pwm_i(pwm_i), .force_i(force_i), .port_data_i(port_data_i),
    .port_dir_i(port_dir_i), .pin_o(pin_o), .pin_oe_o(pin_oe_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // pin and enable as combinational functions of the present inputs
  task automatic chk_pins();
    for (int k = 0; k < NUM_CH; k++) begin
      logic [1:0] m;
      m = mode_i[2*k +: 2];
      chk((m == 2'b00) ? "R3 pin" : "R4 pin", pin_o[k],
          (m == 2'b00) ? port_data_i[k] : exp_st[k]);
      chk("R5 oe", pin_oe_o[k], port_dir_i[k]);
    end
  endtask

  // probe: mode 11, direction out, no event, so the pin shows the state bit
  task automatic probe(input string tag);
    @(negedge clk);
    match_i = '0; force_i = '0; mode_i = '1; port_dir_i = '1;
    #1;
    for (int k = 0; k < NUM_CH; k++) chk(tag, pin_o[k], exp_st[k]);
  endtask

  function automatic logic model(input logic s, input logic [1:0] m,
                                 input logic mt, input logic fc, input logic pw);
    logic ev;
    ev = mt | (fc & ~pw);
    if (!ev) return s;
    case (m)
      2'b01:   return ~s;
      2'b10:   return 1'b0;
      2'b11:   return 1'b1;
      default: return s;
    endcase
  endfunction

  initial begin
    #(PERIOD*200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    probe("R1 reset state");

    // sweep: 7-bit code = {mode[1:0], match, force, pwm, pdata, dir}
    for (int i = 0; i < 256; i++) begin
      int c0, c1;
      string tag;
      c0 = i % 128;
      c1 = (i * 37 + 11) % 128;
      @(negedge clk);
      mode_i      = {c1[6:5], c0[6:5]};
      match_i     = {c1[4], c0[4]};
      force_i     = {c1[3], c0[3]};
      pwm_i       = c0[2];
      port_data_i = {c1[1], c0[1]};
      port_dir_i  = {c1[0], c0[0]};
      #1;
      chk_pins();
      for (int k = 0; k < NUM_CH; k++)
        exp_st[k] = model(exp_st[k], mode_i[2*k +: 2], match_i[k], force_i[k], pwm_i);
      if (c0[6:5] == 2'b00)          tag = "R3 off hold";
      else if (c0[4] && c0[3] && !c0[2]) tag = "R8 match+force";
      else if (!c0[4] && c0[3] && c0[2]) tag = "R7 pwm force";
      else if (!c0[4] && c0[3])      tag = "R6 force";
      else                           tag = "R2 match";
      @(posedge clk);
      @(negedge clk);
      match_i = '0; force_i = '0; mode_i = '1; port_dir_i = '1;
      #1;
      chk(tag, pin_o[0], exp_st[0]);
      chk("R11 ch1 independent", pin_o[1], exp_st[1]);
    end

    // R9: set state, then swing pwm and mode with no event
    @(negedge clk);
    pwm_i = 1'b0; mode_i = '1; match_i = '1;
    @(negedge clk);
    match_i = '0; exp_st = '1;
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      pwm_i = j[0]; mode_i = {j[2:1], ~j[2:1]};
    end
    probe("R9 hold across mode/pwm");

    // R10: mode change mid-cycle switches the pin source immediately
    @(negedge clk);
    port_data_i = '0; mode_i = '1;
    #1;
    chk("R10 owned", pin_o[0], 1'b1);
    mode_i = '0;
    #1;
    chk("R10 released", pin_o[0], 1'b0);
    mode_i = 4'b0101;
    #1;
    chk("R10 retaken", pin_o[0], 1'b1);

    // R6: preset through force with direction input, then enable
    @(negedge clk);
    port_dir_i = '0; pwm_i = 1'b0; mode_i = 4'b1010; force_i = 2'b01;
    #1;
    chk("R5 oe low", pin_oe_o[0], 1'b0);
    @(negedge clk);
    force_i = '0; exp_st[0] = 1'b0;
    probe("R6 preset by force");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule